// File: doc/BRIEF.md
# Auto-Increment Colour Lookup Table

This block turns pixel codes into 8-bit red, green and blue values through a 256-entry colour table. Software fills the table through one write bus that carries a register-select field and a data word. One register sets an entry pointer. Each write to the colour register stores a word at that pointer and moves the pointer on by one. A full reload is therefore a pointer write of zero followed by 256 colour writes.

On the pixel side, a mode input picks how the pixel code addresses the table. In the 1, 2, 4 and 8 bits-per-pixel modes only the low bits of the pixel are used as one index, and all three channels come from that one entry. In the 16 bits-per-pixel mode each channel uses its own 8-bit window of the pixel. The windows overlap by four bits, so each channel reads a different entry. The result is registered, which gives one clock of latency. Video timing, pixel fetch and digital-to-analogue conversion sit outside this block.

Top module: `cpal_lookup`

## Requirements
- R1: A write with `wr_sel` = 0 loads the entry pointer from `wr_data[7:0]` and does not change the table.
- R2: A write with `wr_sel` = 1 stores `wr_data[23:0]` at the entry the pointer names, and the pointer then advances by one. Back-to-back colour writes fill consecutive entries.
- R3: The pointer is 8 bits wide. A colour write at entry 255 leaves the pointer at 0, so the next colour write lands in entry 0.
- R4: A write with `wr_sel` = 2 or 3 changes neither the table nor the pointer.
- R5: Each entry holds red in bits [7:0], green in bits [15:8] and blue in bits [23:16]. In mode 3 (8 bpp) the index is `pix_in[7:0]`, bits [15:8] are ignored, and all three channels come from that one entry.
- R6: Modes 0, 1 and 2 (1, 2 and 4 bpp) use only the low 1, 2 or 4 pixel bits as the index. All higher pixel bits are ignored, and all three channels come from that one entry.
- R7: Modes 4 to 7 (16 bpp) use three indices: red from `pix_in[7:0]`, green from `pix_in[11:4]`, blue from `pix_in[15:8]`. Each channel takes its own field of its own entry.
- R8: The outputs show the lookup for the pixel and mode that were present at the previous rising clock edge. A change in the inputs between edges does not reach the outputs.
- R9: When a colour write and a lookup of the same entry happen at the same edge, the lookup returns the value the entry held before the write. The next lookup returns the new value.
- R10: While `rst_n` is low, the three outputs are 0. After reset the pointer is 0, so the first colour write with no pointer write goes to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register bus |
| wr_sel | input | 2 | Register select: 0 pointer, 1 colour, 2 and 3 unused |
| wr_data | input | 32 | Write data |
| pix_mode | input | 3 | Pixel mode: 0..3 are 1/2/4/8 bpp, 4..7 are 16 bpp |
| pix_in | input | 16 | Pixel code |
| red_out | output | 8 | Red channel |
| green_out | output | 8 | Green channel |
| blue_out | output | 8 | Blue channel |

## Verification
The bench builds the block with its defaults: an 8-bit index, a 16-bit pixel and 8-bit channels. At this size the whole table can be loaded and read back through every entry in each direct mode, and the pointer wrap can be reached with a few writes. In 16 bpp mode a strided sweep plus the all-ones and nibble-edge pixel codes exercise each overlapping window. The expected colours come from an arithmetic fill pattern held in the bench. Targeted sequences cover the unused selects, a write and a lookup at the same edge, and the first write after reset.

// File: rtl/cpal_pkg.sv
package cpal_pkg;

   // register-select codes on the write bus
   typedef enum logic [1:0] {
      SEL_POINTER = 2'd0,
      SEL_COLOUR  = 2'd1,
      SEL_SPARE2  = 2'd2,
      SEL_SPARE3  = 2'd3
   } reg_sel_e;

   // number of colour channels (red, green, blue)
   localparam int NUM_CH = 3;
   localparam int CH_RED = 0;
   localparam int CH_GRN = 1;
   localparam int CH_BLU = 2;

endpackage

// File: rtl/cpal_regif.sv
module cpal_regif
   import cpal_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int DATA_W = 32,
   parameter int ENT_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              tab_we,
   output logic [IDX_W-1:0]  tab_waddr,
   output logic [ENT_W-1:0]  tab_wdata
);

   generate
      if (DATA_W < ENT_W) begin : g_bad_data
         $error("cpal_regif: DATA_W must hold one table entry");
      end
      if (DATA_W < IDX_W) begin : g_bad_idx
         $error("cpal_regif: DATA_W must hold one pointer value");
      end
      if (DATA_W > ENT_W) begin : g_spare_bits
         logic unused_hi;
         assign unused_hi = ^wr_data[DATA_W-1:ENT_W];
      end
   endgenerate

   logic [IDX_W-1:0] ptr_q;
   logic             ld_ptr;

   assign ld_ptr = wr_en && (wr_sel == SEL_POINTER);
   assign tab_we = wr_en && (wr_sel == SEL_COLOUR);

   // pointer: load on pointer write, advance after each colour write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (ld_ptr)
         ptr_q <= wr_data[IDX_W-1:0];
      else if (tab_we)
         ptr_q <= ptr_q + 1'b1;
   end

   assign tab_waddr = ptr_q;
   assign tab_wdata = wr_data[ENT_W-1:0];

   a_r1_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld_ptr |=> tab_waddr == $past(wr_data[IDX_W-1:0]));

   a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      tab_we |=> tab_waddr == IDX_W'($past(tab_waddr) + 1));

   a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tab_we && (tab_waddr == '1)) |=> (tab_waddr == '0));

   a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_sel[1]) |=> $stable(tab_waddr));

endmodule

// File: rtl/cpal_index_sel.sv
module cpal_index_sel
   import cpal_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int PIX_W = 16
) (
   input  logic [2:0]                   pix_mode,
   input  logic [PIX_W-1:0]             pix_in,
   output logic [NUM_CH-1:0][IDX_W-1:0] idx
);

   localparam int HALF = IDX_W / 2;

   generate
      if (PIX_W != 2 * IDX_W) begin : g_bad_pix
         $error("cpal_index_sel: PIX_W must be twice IDX_W");
      end
      if ((IDX_W % 2) != 0) begin : g_bad_half
         $error("cpal_index_sel: IDX_W must be even");
      end
   endgenerate

   logic [IDX_W-1:0] direct;

   // direct modes keep only the low 2**mode pixel bits
   always_comb begin
      direct = '0;
      for (int b = 0; b < IDX_W; b++)
         direct[b] = pix_in[b] && (b < (32'sd1 << pix_mode[1:0]));
   end

   always_comb begin
      if (pix_mode[2]) begin
         idx[CH_RED] = pix_in[IDX_W-1:0];
         idx[CH_GRN] = pix_in[IDX_W+HALF-1:HALF];
         idx[CH_BLU] = pix_in[2*IDX_W-1:IDX_W];
      end else begin
         idx[CH_RED] = direct;
         idx[CH_GRN] = direct;
         idx[CH_BLU] = direct;
      end
   end

   always_comb begin
      if (!pix_mode[2]) begin
         a_r5_one_entry: assert (idx[CH_RED] == idx[CH_GRN] && idx[CH_GRN] == idx[CH_BLU]);
         a_r6_width: assert ((idx[CH_RED] >> (32'sd1 << pix_mode[1:0])) == '0);
      end else begin
         a_r7_overlap: assert (idx[CH_GRN][HALF-1:0] == idx[CH_RED][IDX_W-1:HALF] &&
                               idx[CH_GRN][IDX_W-1:HALF] == idx[CH_BLU][HALF-1:0]);
      end
   end

endmodule

// File: rtl/cpal_table.sv
module cpal_table
   import cpal_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int CH_W  = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [IDX_W-1:0]             waddr,
   input  logic [NUM_CH*CH_W-1:0]       wdata,
   input  logic [NUM_CH-1:0][IDX_W-1:0] raddr,
   output logic [NUM_CH-1:0][CH_W-1:0]  rdata
);

   localparam int DEPTH = 1 << IDX_W;
   localparam int ENT_W = NUM_CH * CH_W;

   generate
      if (IDX_W > 12) begin : g_too_deep
         $error("cpal_table: IDX_W above 12 makes the table too large");
      end
   endgenerate

   logic [ENT_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   // one registered read port per channel; each reads only its own field
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_port
         logic [CH_W-1:0] rd_q;
         logic [ENT_W-1:0] word;
         assign word = mem[raddr[c]];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rd_q <= '0;
            else
               rd_q <= word[c*CH_W +: CH_W];
         end
         assign rdata[c] = rd_q;
      end
   endgenerate

endmodule

// File: rtl/cpal_lookup.sv
module cpal_lookup
   import cpal_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int CH_W   = 8,
   parameter int PIX_W  = 2 * IDX_W,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        pix_mode,
   input  logic [PIX_W-1:0]  pix_in,
   output logic [CH_W-1:0]   red_out,
   output logic [CH_W-1:0]   green_out,
   output logic [CH_W-1:0]   blue_out
);

   localparam int ENT_W = NUM_CH * CH_W;

   logic                         tab_we;
   logic [IDX_W-1:0]             tab_waddr;
   logic [ENT_W-1:0]             tab_wdata;
   logic [NUM_CH-1:0][IDX_W-1:0] rd_idx;
   logic [NUM_CH-1:0][CH_W-1:0]  rd_col;

   cpal_regif #(
      .IDX_W (IDX_W),
      .DATA_W(DATA_W),
      .ENT_W (ENT_W)
   ) u_regif (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .tab_we   (tab_we),
      .tab_waddr(tab_waddr),
      .tab_wdata(tab_wdata)
   );

   cpal_index_sel #(
      .IDX_W(IDX_W),
      .PIX_W(PIX_W)
   ) u_index (
      .pix_mode(pix_mode),
      .pix_in  (pix_in),
      .idx     (rd_idx)
   );

   cpal_table #(
      .IDX_W(IDX_W),
      .CH_W (CH_W)
   ) u_table (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (tab_we),
      .waddr(tab_waddr),
      .wdata(tab_wdata),
      .raddr(rd_idx),
      .rdata(rd_col)
   );

   assign red_out   = rd_col[CH_RED];
   assign green_out = rd_col[CH_GRN];
   assign blue_out  = rd_col[CH_BLU];

   // set once the output registers hold a real lookup
   logic primed_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed_q <= 1'b0;
      else        primed_q <= 1'b1;
   end

   a_r8_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && !$past(tab_we) && $stable(pix_in) && $stable(pix_mode))
      |=> ($stable(red_out) && $stable(green_out) && $stable(blue_out)));

   a_r10_reset_zero: assert property (@(posedge clk)
      !rst_n |=> (red_out == '0 && green_out == '0 && blue_out == '0));

endmodule

// File: tb/tb_cpal_lookup.sv
`timescale 1ns/1ps
module tb_cpal_lookup;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = 32'd0;
   logic [2:0]  pix_mode = 3'd3;
   logic [15:0] pix_in = 16'd0;
   logic [7:0]  red_out, green_out, blue_out;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [23:0] tab [256];
   logic [7:0]  ptr_m = 8'd0;

   always #2.5 clk = ~clk;

   cpal_lookup dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pix_mode(pix_mode), .pix_in(pix_in),
      .red_out(red_out), .green_out(green_out), .blue_out(blue_out)
   );

   function automatic logic [23:0] pat(input int i, input int salt);
      pat = {8'((i * 7 + 3 + salt) % 256), 8'((i ^ 8'hA5) + salt), 8'(255 - i + salt)};
   endfunction

   task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%06h exp=%06h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
      if (s == 2'd0) ptr_m = d[7:0];
      else if (s == 2'd1) begin tab[ptr_m] = d[23:0]; ptr_m = ptr_m + 8'd1; end
   endtask

   function automatic logic [23:0] expect_rgb(input logic [2:0] m, input logic [15:0] p);
      int ir, ig, ib;
      if (m < 3'd4) begin
         ir = int'(p) % (1 << (1 << m));
         ig = ir; ib = ir;
      end else begin
         ir = int'(p) % 256;
         ig = (int'(p) / 16) % 256;
         ib = int'(p) / 256;
      end
      expect_rgb = {tab[ib][23:16], tab[ig][15:8], tab[ir][7:0]};
   endfunction

   task automatic look(input string req, input logic [2:0] m, input logic [15:0] p);
      @(negedge clk);
      pix_mode = m; pix_in = p;
      @(negedge clk);
      chk(req, {blue_out, green_out, red_out}, expect_rgb(m, p));
   endtask

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [23:0] oldv, newv;
      repeat (3) @(negedge clk);
      // R10: outputs are zero while reset is held
      chk("R10 reset outputs", {blue_out, green_out, red_out}, 24'd0);
      rst_n = 1'b1;
      // R10: pointer starts at 0
      wr(2'd1, 32'hFF_123456);
      look("R10 first write at entry 0", 3'd3, 16'h0000);

      // R1/R2: full reload from entry 0
      wr(2'd0, 32'hFFFF_FF00);
      for (int i = 0; i < 256; i++) wr(2'd1, {8'hEE, pat(i, 0)});
      // R5: 8 bpp sweep with junk in the high byte
      for (int i = 0; i < 256; i++) look("R5 8bpp", 3'd3, 16'(((i * 13) % 256) * 256 + i));
      // R6: narrow modes ignore high pixel bits
      for (int m = 0; m < 3; m++)
         for (int i = 0; i < 256; i++) look("R6 narrow", 3'(m), 16'(i * 257 + 40 * m));
      // R7: 16 bpp windows
      for (int p = 0; p < 65536; p += 37) look("R7 16bpp", 3'(4 + (p % 4)), 16'(p));
      look("R7 16bpp edge", 3'd4, 16'hFFFF);
      look("R7 16bpp edge", 3'd5, 16'h0FF0);
      look("R7 16bpp edge", 3'd7, 16'hF00F);

      // R1: pointer load to the middle, neighbours untouched
      wr(2'd0, 32'd100);
      wr(2'd1, 32'h00_ABCDEF);
      look("R1 pointer load", 3'd3, 16'd100);
      look("R1 neighbour below", 3'd3, 16'd99);
      look("R1 neighbour above", 3'd3, 16'd101);

      // R3: wrap from 255 to 0
      wr(2'd0, 32'd254);
      for (int i = 0; i < 3; i++) wr(2'd1, {8'h00, pat(i, 91)});
      look("R3 wrap 254", 3'd3, 16'd254);
      look("R3 wrap 255", 3'd3, 16'd255);
      look("R3 wrap 0", 3'd3, 16'd0);
      look("R3 entry 1 kept", 3'd3, 16'd1);

      // R4: spare selects change nothing
      wr(2'd0, 32'd50);
      @(negedge clk); wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'h00_111111;
      @(negedge clk); wr_sel = 2'd3; wr_data = 32'h00_222222;
      @(posedge clk); #1 wr_en = 1'b0;
      for (int i = 0; i < 256; i++) look("R4 table unchanged", 3'd3, 16'(i));
      wr(2'd1, 32'h00_5A5A5A);
      look("R4 pointer unchanged", 3'd3, 16'd50);
      look("R4 pointer unchanged next", 3'd3, 16'd51);

      // R9: same-edge write and lookup
      oldv = tab[77];
      wr(2'd0, 32'd77);
      newv = 24'hC3_3C_99;
      @(negedge clk);
      pix_mode = 3'd3; pix_in = 16'd77;
      wr_en = 1'b1; wr_sel = 2'd1; wr_data = {8'h00, newv};
      @(posedge clk); #1 wr_en = 1'b0;
      tab[77] = newv; ptr_m = 8'd78;
      @(negedge clk);
      chk("R9 old value on collision", {blue_out, green_out, red_out}, oldv);
      @(negedge clk);
      chk("R9 new value next cycle", {blue_out, green_out, red_out}, newv);

      // R8: input change between edges does not reach outputs
      look("R8 settle", 3'd3, 16'd10);
      @(negedge clk);
      pix_in = 16'd20;
      #1;
      chk("R8 no early change", {blue_out, green_out, red_out}, expect_rgb(3'd3, 16'd10));
      @(negedge clk);
      chk("R8 after one edge", {blue_out, green_out, red_out}, expect_rgb(3'd3, 16'd20));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule